// File: doc/BRIEF.md
# Privilege-Masked Interrupt Pending Arbiter

This block keeps two small registered bit vectors for a processor core: one recording which interrupt causes are waiting, and one recording which causes software has allowed. Each cause belongs to one of three privilege groups: user, supervisor or machine. A group-wide enable input gates every cause in that group. A cause can be taken only when it is waiting, allowed, and its group is globally enabled.

The block raises a single request line whenever at least one cause can be taken. It also gives the index of the one to service, which is always the lowest eligible index. Interrupt sources set and clear waiting bits with per-cause strobes. A clear-all strobe wipes every waiting bit. Software can read both vectors and can overwrite each one as a whole.

Top module: `prv_irq_arb`

## Requirements
- R1: A cause is eligible only when its pending bit, its enable bit and its group enable are all 1. `irq_o` is 1 exactly when at least one cause is eligible. The request and cause outputs react combinationally, in the same cycle, to the registered vectors and the group enables.
- R2: `m_gie_i` is the group enable for the machine causes: software 3, timer 7 and external 11.
- R3: `s_gie_i` is the group enable for the supervisor causes: software 1, timer 5 and external 9.
- R4: `u_gie_i` is the group enable for the user causes: software 0, timer 4 and external 8.
- R5: `cause_o` gives the lowest eligible index. When no cause is eligible, `cause_o` is 0.
- R6: A post strobe sets the pending bit of `post_cause_i`. A clear strobe clears the pending bit of `clr_cause_i`. Both take effect from the next cycle. When both strobes name the same cause, clear wins. A cause index of 12 or more is ignored. Neither strobe changes the enable vector.
- R7: A clear-all strobe makes the pending vector all zero from the next cycle and overrides any post. The enable vector is unchanged.
- R8: After reset, both vectors read as zero.
- R9: A pending write replaces the whole pending vector with `pend_wdata_i`, and an enable write replaces the enable vector with `en_wdata_i`, visible on the read ports the next cycle. A pending write takes precedence over post, clear and clear-all in the same cycle.
- R10: Bit positions 2, 6 and 10 of both vectors always read 0, whatever is written or posted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| post_valid_i | input | 1 | Set one pending bit |
| post_cause_i | input | 4 | Cause index for post |
| clr_valid_i | input | 1 | Clear one pending bit |
| clr_cause_i | input | 4 | Cause index for clear |
| clr_all_i | input | 1 | Zero the pending vector |
| pend_we_i | input | 1 | Overwrite pending vector |
| pend_wdata_i | input | 12 | New pending vector |
| pend_rdata_o | output | 12 | Current pending vector |
| en_we_i | input | 1 | Overwrite enable vector |
| en_wdata_i | input | 12 | New enable vector |
| en_rdata_o | output | 12 | Current enable vector |
| m_gie_i | input | 1 | Machine group enable |
| s_gie_i | input | 1 | Supervisor group enable |
| u_gie_i | input | 1 | User group enable |
| irq_o | output | 1 | Some cause is eligible |
| cause_o | output | 4 | Lowest eligible cause index |

## Verification
Updates to the pending vector can collide in one cycle: a post with a clear of the same cause, a clear-all with a post, and a full pending write with any of these. Directed steps drive each such pair together. A long random phase then lets all update sources fire at once against a behavioural model that applies the stated precedence. The result is judged on the pending read port in the following cycle, and on the request and cause outputs, which must follow the group enables without delay.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  parameter int unsigned NCAUSE = 12;
  parameter int unsigned CW = $clog2(NCAUSE);

  typedef enum logic [1:0] {
    PRV_U   = 2'd0,
    PRV_S   = 2'd1,
    PRV_RSV = 2'd2,
    PRV_M   = 2'd3
  } prv_e;

  // slots whose low two index bits name the reserved level are unimplemented
  function automatic logic [NCAUSE-1:0] impl_mask();
    logic [NCAUSE-1:0] m;
    for (int i = 0; i < int'(NCAUSE); i++) m[i] = (i % 4) != 2;
    return m;
  endfunction
endpackage

// File: rtl/irq_pend_store.sv
module irq_pend_store
  import irq_arb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              post_valid_i,
  input  logic [CW-1:0]     post_cause_i,
  input  logic              clr_valid_i,
  input  logic [CW-1:0]     clr_cause_i,
  input  logic              clr_all_i,
  input  logic              we_i,
  input  logic [NCAUSE-1:0] wdata_i,
  output logic [NCAUSE-1:0] q_o
);
  localparam logic [NCAUSE-1:0] IMPL = impl_mask();

  logic [NCAUSE-1:0] q, d, set_v, clr_v;

  always_comb begin
    for (int i = 0; i < int'(NCAUSE); i++) begin
      set_v[i] = post_valid_i && (post_cause_i == CW'(i));
      clr_v[i] = clr_valid_i && (clr_cause_i == CW'(i));
    end
  end

  always_comb begin
    if (we_i)           d = wdata_i;
    else if (clr_all_i) d = '0;
    else                d = (q | set_v) & ~clr_v;
    d = d & IMPL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign q_o = q;

  assert_post_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_valid_i && !we_i && !clr_all_i && post_cause_i < CW'(NCAUSE)
     && post_cause_i[1:0] != 2'd2
     && !(clr_valid_i && clr_cause_i == post_cause_i))
    |=> q[$past(post_cause_i)]);

  assert_clr_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_valid_i && !we_i && clr_cause_i < CW'(NCAUSE)) |=> !q[$past(clr_cause_i)]);

  assert_clr_all_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_all_i && !we_i) |=> (q == '0));

  assert_resv_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q[2] == 1'b0) && (q[6] == 1'b0) && (q[10] == 1'b0));
endmodule

// File: rtl/irq_en_store.sv
module irq_en_store
  import irq_arb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [NCAUSE-1:0] wdata_i,
  output logic [NCAUSE-1:0] q_o
);
  localparam logic [NCAUSE-1:0] IMPL = impl_mask();

  logic [NCAUSE-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= wdata_i & IMPL;
  end

  assign q_o = q;

  assert_en_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q));
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_arb_pkg::*;
(
  input  logic [NCAUSE-1:0] pend_i,
  input  logic [NCAUSE-1:0] en_i,
  input  logic              m_gie_i,
  input  logic              s_gie_i,
  input  logic              u_gie_i,
  output logic [NCAUSE-1:0] elig_o
);
  logic [NCAUSE-1:0] gmask;

  for (genvar i = 0; i < int'(NCAUSE); i++) begin : g_mask
    localparam prv_e LVL = prv_e'(i % 4);
    if (LVL == PRV_M)      begin : g_m assign gmask[i] = m_gie_i; end
    else if (LVL == PRV_S) begin : g_s assign gmask[i] = s_gie_i; end
    else if (LVL == PRV_U) begin : g_u assign gmask[i] = u_gie_i; end
    else                   begin : g_r assign gmask[i] = 1'b0;    end
  end

  assign elig_o = pend_i & en_i & gmask;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
(
  input  logic [NCAUSE-1:0] elig_i,
  output logic              irq_o,
  output logic [CW-1:0]     cause_o
);
  logic found;

  always_comb begin
    found   = 1'b0;
    cause_o = '0;
    for (int i = 0; i < int'(NCAUSE); i++) begin
      if (elig_i[i] && !found) begin
        found   = 1'b1;
        cause_o = CW'(i);
      end
    end
  end

  assign irq_o = found;

  always_comb begin
    assert_lowest_R5: assert (!irq_o || ((elig_i & ((NCAUSE'(1) << cause_o) - NCAUSE'(1))) == '0));
    assert_req_any_R1: assert (irq_o == (elig_i != '0));
  end
endmodule

// File: rtl/prv_irq_arb.sv
module prv_irq_arb
  import irq_arb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              post_valid_i,
  input  logic [CW-1:0]     post_cause_i,
  input  logic              clr_valid_i,
  input  logic [CW-1:0]     clr_cause_i,
  input  logic              clr_all_i,
  input  logic              pend_we_i,
  input  logic [NCAUSE-1:0] pend_wdata_i,
  output logic [NCAUSE-1:0] pend_rdata_o,
  input  logic              en_we_i,
  input  logic [NCAUSE-1:0] en_wdata_i,
  output logic [NCAUSE-1:0] en_rdata_o,
  input  logic              m_gie_i,
  input  logic              s_gie_i,
  input  logic              u_gie_i,
  output logic              irq_o,
  output logic [CW-1:0]     cause_o
);
  logic [NCAUSE-1:0] pend, en, elig;

  irq_pend_store i_pend (
    .clk_i, .rst_ni, .post_valid_i, .post_cause_i, .clr_valid_i, .clr_cause_i,
    .clr_all_i, .we_i(pend_we_i), .wdata_i(pend_wdata_i), .q_o(pend)
  );

  irq_en_store i_en (
    .clk_i, .rst_ni, .we_i(en_we_i), .wdata_i(en_wdata_i), .q_o(en)
  );

  irq_gate i_gate (
    .pend_i(pend), .en_i(en), .m_gie_i, .s_gie_i, .u_gie_i, .elig_o(elig)
  );

  irq_pick i_pick (.elig_i(elig), .irq_o, .cause_o);

  assign pend_rdata_o = pend;
  assign en_rdata_o   = en;

  assert_sel_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend[cause_o] && en[cause_o]));
  assert_m_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && cause_o[1:0] == 2'd3) |-> m_gie_i);
  assert_s_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && cause_o[1:0] == 2'd1) |-> s_gie_i);
  assert_u_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && cause_o[1:0] == 2'd0) |-> u_gie_i);
  assert_idle_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (cause_o == '0));
  assert_pwrite_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_we_i |=> (pend_rdata_o == ($past(pend_wdata_i) & impl_mask())));
endmodule

// File: tb/test_prv_irq_arb.sv
`timescale 1ns/1ps
module test_prv_irq_arb;
  localparam int N = 12;
  localparam int IMPL = 'hBBB;

  logic clk = 0, rst_n = 0;
  logic post_v = 0, clr_v = 0, clr_all = 0, pend_we = 0, en_we = 0;
  logic [3:0] post_c = 0, clr_c = 0;
  logic [11:0] pend_wd = 0, en_wd = 0;
  logic m_gie = 0, s_gie = 0, u_gie = 0;
  logic [11:0] pend_rd, en_rd;
  logic irq;
  logic [3:0] cause;

  int checks = 0, errors = 0;
  int m_pend = 0, m_en = 0;

  always #4 clk = ~clk;

  prv_irq_arb i_prv_irq_arb (
    .clk_i(clk), .rst_ni(rst_n),
    .post_valid_i(post_v), .post_cause_i(post_c),
    .clr_valid_i(clr_v), .clr_cause_i(clr_c), .clr_all_i(clr_all),
    .pend_we_i(pend_we), .pend_wdata_i(pend_wd), .pend_rdata_o(pend_rd),
    .en_we_i(en_we), .en_wdata_i(en_wd), .en_rdata_o(en_rd),
    .m_gie_i(m_gie), .s_gie_i(s_gie), .u_gie_i(u_gie),
    .irq_o(irq), .cause_o(cause)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int group_on(int i);
    case (i % 4)
      0: return int'(u_gie);
      1: return int'(s_gie);
      3: return int'(m_gie);
      default: return 0;
    endcase
  endfunction

  // compare outputs to the model, then advance the model across one edge
  task automatic cyc(string req);
    int elig = 0, exp_c = 0, exp_i = 0;
    #1;
    for (int i = 0; i < N; i++)
      if (((m_pend >> i) & 1) && ((m_en >> i) & 1) && group_on(i)) elig |= (1 << i);
    for (int i = N - 1; i >= 0; i--)
      if ((elig >> i) & 1) begin exp_c = i; exp_i = 1; end
    check(req, "pend", int'(pend_rd), m_pend);
    check(req, "en", int'(en_rd), m_en);
    check(req, "irq", int'(irq), exp_i);
    check(req, "cause", int'(cause), exp_c);
    if (pend_we) m_pend = int'(pend_wd);
    else if (clr_all) m_pend = 0;
    else begin
      if (post_v && post_c < N) m_pend |= (1 << post_c);
      if (clr_v && clr_c < N) m_pend &= ~(1 << clr_c);
    end
    m_pend &= IMPL;
    if (en_we) m_en = int'(en_wd) & IMPL;
    @(negedge clk);
    post_v = 0; clr_v = 0; clr_all = 0; pend_we = 0; en_we = 0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cyc("R8");
    en_we = 1; en_wd = 12'hFFF; cyc("R9");
    cyc("R10");
    post_v = 1; post_c = 7; cyc("R6");
    cyc("R2");
    m_gie = 1; cyc("R2");
    post_v = 1; post_c = 5; cyc("R6");
    post_v = 1; post_c = 4; cyc("R6");
    s_gie = 1; cyc("R3");
    u_gie = 1; cyc("R4");
    m_gie = 0; u_gie = 0; cyc("R5");
    post_v = 1; post_c = 2; cyc("R10");
    post_v = 1; post_c = 14; cyc("R6");
    post_v = 1; post_c = 9; clr_v = 1; clr_c = 9; cyc("R6");
    u_gie = 1; m_gie = 1; clr_v = 1; clr_c = 4; cyc("R6");
    clr_all = 1; post_v = 1; post_c = 3; cyc("R7");
    cyc("R7");
    pend_we = 1; pend_wd = 12'hFFF; clr_all = 1; post_v = 1; post_c = 1; cyc("R9");
    cyc("R10");
    en_we = 1; en_wd = 12'h800; cyc("R9");
    cyc("R1");
    s_gie = 0; u_gie = 0; cyc("R1");
    for (int k = 0; k < 4000; k++) begin
      post_v = 1'($urandom); post_c = 4'($urandom);
      clr_v = 1'($urandom); clr_c = 4'($urandom);
      clr_all = ($urandom % 16) == 0;
      pend_we = ($urandom % 12) == 0; pend_wd = 12'($urandom);
      en_we = ($urandom % 8) == 0; en_wd = 12'($urandom);
      m_gie = 1'($urandom); s_gie = 1'($urandom); u_gie = 1'($urandom);
      cyc("R1");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule